// File: doc/BRIEF.md
# Cross-Feedback Current-Sharing Controller

This block is the digital control core for a bank of inverter modules whose outputs are wired in parallel. It runs one outer proportional-integral loop on the shared output voltage. The result of that loop is a single current reference, and every module's inner loop uses it. Each inner loop is also proportional-integral, and all of them use the same gains. The feedback of each inner loop is not the module's own inductor current. It is the sum of the inductor currents of all the other modules. This cross coupling pushes the modules toward equal instantaneous currents without measuring each module's input voltage.

Each time the sample strobe is high, the block reads the voltage reference, the measured output voltage and one current word per module. It then evaluates both loop levels combinationally. On that same clock edge it registers one signed compare command per module. The commands are clamped to the carrier range, and a valid flag marks the cycle in which they are new. Every integrator has anti-windup: when the stage output would leave the carrier range, its integrator keeps its old value.

Top module: `ccs_ctrl`

## Requirements
- R1: During reset and in the first cycle after reset, every command is 0 and `duty_vld` is 0. The first sample after reset is computed with all integrators at 0.
- R2: `duty_vld` is high for exactly the one cycle after each clock edge at which `smp_stb` was high. Commands change only on such edges.
- R3: The outer stage uses the error ev = v_ref − v_meas, the proportional term (KP_V·ev)>>>FRAC, and the integrator candidate clamp(iv + (KI_V·ev)>>>FRAC). The reference is iref = clamp(proportional term + candidate). Here clamp limits a value to [−LIM, +LIM], and >>> is an arithmetic right shift.
- R4: The inner error of module j is iref − (Σ all i_meas − i_meas[j]). Module j's own current therefore has no effect on its own command.
- R5: Each inner stage follows the same formula as R3, using its own error and the shared gains KP_I and KI_I. Its result is the command of module j.
- R6: Every command stays within [−LIM, +LIM].
- R7: If the unclamped sum of a stage's proportional term and integrator candidate falls outside [−LIM, +LIM], that stage's integrator keeps its previous value. Otherwise it takes the candidate value.
- R8: An integrator never holds a value outside [−LIM, +LIM].
- R9: Input changes without a strobe leave the commands and the integrators untouched.
- R10: Module j's command sits in bits [j·OW +: OW] of `duty`, and module j's current sits in bits [j·DW +: DW] of `i_meas`. All words are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe; one control step per high cycle |
| v_ref | input | DW | Output voltage set point, signed |
| v_meas | input | DW | Sensed output voltage, signed |
| i_meas | input | N_MOD·DW | Sensed inductor currents, one signed word per module |
| duty | output | N_MOD·OW | Registered compare commands, one signed word per module |
| duty_vld | output | 1 | High for the cycle in which the commands are new |

## Verification
The bench drives a large voltage error that pins the reference at the limit, and then reverses it. A design without anti-windup would keep integrating and stay saturated for many samples after the reversal. A design that clamps only the output would return with the wrong value. The bench also changes a module's own current while holding the others fixed. If a module were fed back its own current or the full total, its command would move. Inputs are toggled without a strobe and then followed by one real sample. This exposes integrators that update on every cycle, and it also exposes a valid flag that is stuck high or one cycle late.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
   localparam int WIDE = 64;

   function automatic logic signed [WIDE-1:0] sat_wide(input logic signed [WIDE-1:0] x,
                                                       input longint lim);
      logic signed [WIDE-1:0] hi;
      logic signed [WIDE-1:0] lo;
      hi = lim;
      lo = -lim;
      if (x > hi) return hi;
      else if (x < lo) return lo;
      else return x;
   endfunction
endpackage

// File: rtl/ccs_pi.sv
module ccs_pi
   import ccs_pkg::*;
#(
   parameter int     EW   = 13,
   parameter int     OW   = 12,
   parameter int     FRAC = 8,
   parameter longint LIM  = 1000,
   parameter longint KP   = 256,
   parameter longint KI   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic signed [EW-1:0] err,
   output logic signed [OW-1:0] u
);
   logic signed [OW-1:0]   integ_q;
   logic signed [WIDE-1:0] e_w, integ_w, p_term, i_term, i_cand, raw, u_w;
   logic                   over;

   assign e_w     = {{(WIDE-EW){err[EW-1]}}, err};
   assign integ_w = {{(WIDE-OW){integ_q[OW-1]}}, integ_q};

   always_comb begin
      p_term = (KP * e_w) >>> FRAC;
      i_term = (KI * e_w) >>> FRAC;
      i_cand = sat_wide(integ_w + i_term, LIM);
      raw    = p_term + i_cand;
      u_w    = sat_wide(raw, LIM);
      over   = (u_w != raw);
   end

   assign u = u_w[OW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)              integ_q <= '0;
      else if (step && !over)  integ_q <= i_cand[OW-1:0];
   end
endmodule

// File: rtl/ccs_peer_sum.sv
module ccs_peer_sum #(
   parameter int N_MOD = 2,
   parameter int DW    = 12,
   parameter int SW    = 14
) (
   input  logic [N_MOD*DW-1:0] i_all,
   output logic [N_MOD*SW-1:0] peer
);
   logic signed [SW-1:0] total;

   always_comb begin
      total = '0;
      for (int k = 0; k < N_MOD; k++)
         total = total + {{(SW-DW){i_all[k*DW+DW-1]}}, i_all[k*DW +: DW]};
   end

   for (genvar j = 0; j < N_MOD; j++) begin : g_peer
      assign peer[j*SW +: SW] = total - {{(SW-DW){i_all[j*DW+DW-1]}}, i_all[j*DW +: DW]};
   end
endmodule

// File: rtl/ccs_ctrl.sv
module ccs_ctrl #(
   parameter int     N_MOD = 2,
   parameter int     DW    = 12,
   parameter int     OW    = 12,
   parameter int     FRAC  = 8,
   parameter longint LIM   = 1000,
   parameter longint KP_V  = 768,
   parameter longint KI_V  = 192,
   parameter longint KP_I  = 640,
   parameter longint KI_I  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_stb,
   input  logic [DW-1:0]       v_ref,
   input  logic [DW-1:0]       v_meas,
   input  logic [N_MOD*DW-1:0] i_meas,
   output logic [N_MOD*OW-1:0] duty,
   output logic                duty_vld
);
   localparam int SW  = DW + $clog2(N_MOD) + 1;
   localparam int EWV = DW + 1;
   localparam int EWI = ((SW > OW) ? SW : OW) + 1;

   if (N_MOD < 2)                  begin : g_bad_n   $error("N_MOD must be at least 2"); end
   if (LIM >= (64'sd1 <<< (OW-1))) begin : g_bad_lim $error("LIM must fit in OW bits"); end
   if (EWI + 24 > 62)              begin : g_bad_w   $error("widths too large for 64-bit math"); end

   logic signed [EWV-1:0]   v_err;
   logic signed [OW-1:0]    iref;
   logic [N_MOD*SW-1:0]     peer;
   logic [N_MOD*OW-1:0]     u_all;
   logic [N_MOD*OW-1:0]     duty_q;
   logic                    vld_q;

   assign v_err = {v_ref[DW-1], v_ref} - {v_meas[DW-1], v_meas};

   ccs_pi #(.EW(EWV), .OW(OW), .FRAC(FRAC), .LIM(LIM), .KP(KP_V), .KI(KI_V)) i_outer (
      .clk(clk), .rst_n(rst_n), .step(smp_stb), .err(v_err), .u(iref)
   );

   ccs_peer_sum #(.N_MOD(N_MOD), .DW(DW), .SW(SW)) i_peer (
      .i_all(i_meas), .peer(peer)
   );

   for (genvar j = 0; j < N_MOD; j++) begin : g_inner
      logic signed [EWI-1:0] e_i;
      logic signed [OW-1:0]  u_j;
      assign e_i = {{(EWI-OW){iref[OW-1]}}, iref}
                 - {{(EWI-SW){peer[j*SW+SW-1]}}, peer[j*SW +: SW]};
      ccs_pi #(.EW(EWI), .OW(OW), .FRAC(FRAC), .LIM(LIM), .KP(KP_I), .KI(KI_I)) i_pi (
         .clk(clk), .rst_n(rst_n), .step(smp_stb), .err(e_i), .u(u_j)
      );
      assign u_all[j*OW +: OW] = u_j;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= smp_stb;
         if (smp_stb) duty_q <= u_all;
      end
   end

   assign duty     = duty_q;
   assign duty_vld = vld_q;
endmodule

// File: rtl/ccs_ctrl_chk.sv
module ccs_ctrl_chk #(
   parameter int     N_MOD = 2,
   parameter int     OW    = 12,
   parameter longint LIM   = 1000
) (
   input logic                clk,
   input logic                rst_n,
   input logic                smp_stb,
   input logic [N_MOD*OW-1:0] duty,
   input logic                duty_vld
);
   assert_vld_follows_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> duty_vld);
   assert_no_spurious_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> !duty_vld);
   assert_hold_without_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !duty_vld |-> $stable(duty));

   for (genvar j = 0; j < N_MOD; j++) begin : g_rng
      assert_cmd_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (longint'($signed(duty[j*OW +: OW])) <= LIM) &&
         (longint'($signed(duty[j*OW +: OW])) >= -LIM));
   end
endmodule

bind ccs_ctrl ccs_ctrl_chk #(.N_MOD(N_MOD), .OW(OW), .LIM(LIM)) i_chk (
   .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .duty(duty), .duty_vld(duty_vld)
);

// File: tb/test_ccs_ctrl.sv
module test_ccs_ctrl;
   localparam int     N    = 2;
   localparam int     DW   = 12;
   localparam int     OW   = 12;
   localparam int     F    = 8;
   localparam longint LIM  = 1000;
   localparam longint KPV  = 768;
   localparam longint KIV  = 192;
   localparam longint KPI  = 640;
   localparam longint KII  = 16;
   localparam int     NV   = 10;
   localparam int VEC [0:NV-1][0:3] = '{
      '{400, 380, 50, 60},   '{400, 390, -20, 30},  '{400, 410, 100, 100},
      '{-300, -250, -80, -60}, '{0, 0, 0, 0},       '{500, 300, 200, -100},
      '{-500, -100, -150, 200}, '{1000, 990, 5, -5}, '{100, 100, 300, 300},
      '{-50, -20, -400, -350}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_stb = 1'b0;
   logic [DW-1:0] v_ref = '0, v_meas = '0;
   logic [N*DW-1:0] i_meas = '0;
   logic [N*OW-1:0] duty;
   logic duty_vld;

   int n_chk = 0, n_bad = 0;
   longint m_iv, m_ii [N], m_u [N];

   always #5 clk = ~clk;

   ccs_ctrl #(.N_MOD(N), .DW(DW), .OW(OW), .FRAC(F), .LIM(LIM),
              .KP_V(KPV), .KI_V(KIV), .KP_I(KPI), .KI_I(KII)) i_ccs_ctrl (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .v_ref(v_ref), .v_meas(v_meas),
      .i_meas(i_meas), .duty(duty), .duty_vld(duty_vld));

   function automatic longint clampl(longint x);
      if (x > LIM) return LIM;
      if (x < -LIM) return -LIM;
      return x;
   endfunction

   task automatic pi_model(input longint e, input longint kp, input longint ki,
                           inout longint integ, output longint u);
      longint p, ic, raw;
      p   = (kp * e) >>> F;
      ic  = clampl(integ + ((ki * e) >>> F));
      raw = p + ic;
      u   = clampl(raw);
      if (u == raw) integ = ic;
   endtask

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint cmd(int j);
      return longint'($signed(duty[j*OW +: OW]));
   endfunction

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic model_reset();
      m_iv = 0;
      for (int j = 0; j < N; j++) m_ii[j] = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; smp_stb = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic set_in(int vr, int vm, int i0, int i1);
      v_ref  = DW'(vr);
      v_meas = DW'(vm);
      i_meas[0 +: DW]  = DW'(i0);
      i_meas[DW +: DW] = DW'(i1);
   endtask

   // R3 R4 R5: one strobe, model update, compare at the next falling edge
   task automatic sample(int vr, int vm, int i0, int i1, string req);
      longint iref, tot, e;
      set_in(vr, vm, i0, i1);
      smp_stb = 1'b1;
      pi_model(longint'(vr - vm), KPV, KIV, m_iv, iref);
      tot = longint'(i0) + longint'(i1);
      e = iref - (tot - longint'(i0));
      pi_model(e, KPI, KII, m_ii[0], m_u[0]);
      e = iref - (tot - longint'(i1));
      pi_model(e, KPI, KII, m_ii[1], m_u[1]);
      @(negedge clk);
      smp_stb = 1'b0;
      check({req, " vld"}, longint'(duty_vld), 1);
      check({req, " cmd0"}, cmd(0), m_u[0]);
      check({req, " cmd1"}, cmd(1), m_u[1]);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      longint keep0, keep1, c_a;
      @(negedge clk);
      // R1: reset state
      check("R1 vld in reset", longint'(duty_vld), 0);
      check("R1 cmd0 in reset", cmd(0), 0);
      do_reset();
      check("R1 vld after reset", longint'(duty_vld), 0);
      check("R1 cmd1 after reset", cmd(1), 0);

      // R3 R4 R5 R10: vector table walked by one loop
      for (int k = 0; k < NV; k++) begin
         sample(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], "R5 table");
         @(negedge clk);
         check("R2 vld one cycle", longint'(duty_vld), 0);
      end

      // R9: inputs move without strobe
      keep0 = cmd(0); keep1 = cmd(1);
      for (int k = 0; k < 4; k++) begin
         set_in(900 - k * 300, -700, 400 * k, -300);
         @(negedge clk);
         check("R9 no vld", longint'(duty_vld), 0);
         check("R9 cmd0 held", cmd(0), keep0);
         check("R9 cmd1 held", cmd(1), keep1);
      end
      sample(120, 100, 10, 20, "R9 integrators untouched");

      // R6 R7 R8: drive into saturation, then reverse
      for (int k = 0; k < 6; k++) sample(2000, 0, 0, 0, "R6 saturate");
      check("R6 cmd0 at limit", cmd(0), LIM);
      sample(-100, 0, 0, 0, "R7 recover");
      sample(-100, 0, 30, -30, "R7 recover");
      for (int k = 0; k < 6; k++) sample(-2000, 2000, 900, 900, "R8 negative");
      check("R6 cmd1 at low limit", cmd(1), -LIM);
      sample(50, 0, -10, 10, "R8 recover");

      // R4: own current has no effect on own command
      do_reset();
      sample(200, 150, 100, 40, "R4 own a");
      c_a = cmd(0);
      do_reset();
      sample(200, 150, -300, 40, "R4 own b");
      check("R4 own current ignored", cmd(0), c_a);

      // R2: back-to-back strobes
      set_in(300, 250, 20, 25);
      smp_stb = 1'b1;
      @(negedge clk);
      check("R2 vld first", longint'(duty_vld), 1);
      @(negedge clk);
      smp_stb = 1'b0;
      check("R2 vld second", longint'(duty_vld), 1);
      @(negedge clk);
      check("R2 vld drops", longint'(duty_vld), 0);

      // R1: mid-run reset clears outputs
      do_reset();
      check("R1 cmd0 cleared", cmd(0), 0);
      sample(300, 250, 20, 25, "R1 fresh integrators");

      summary();
   end
endmodule